// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block performs one integer operation per accepted request on two operands of parameterised width. It keeps a six-bit status register holding carry, parity, auxiliary carry, zero, sign and overflow. Each opcode carries its own policy. It can write the result, write the flags, do both, or do neither. Where an opcode writes flags, it can also spare some of them. Increment and decrement, for example, leave carry as it was. The outcome of each request leaves through a one-entry registered output stage, together with two write-enable strobes. A register file downstream can use the strobes to decide what to commit.

Requests enter on a valid/ready pair. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The flag register changes on that same edge. The result is then presented on the output side from the next cycle. While `out_valid` is high and `out_ready` is low, the output holds still and `in_ready` is low, so no new request is taken and the flags stay frozen. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. Reset is synchronous and active high.

Top module: `flag_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted on edge k appears on the output after edge k with `out_valid` high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged.
- R2: The opcode codes are add=0, subtract=1, compare=2, and=3, or=4, xor=5, test=6, not=7, increment=8, decrement=9, move=10. The results are a+b, a-b, a&b, a|b, a^b, ~a, a+1, a-1 and b (move), each truncated to W bits.
- R3: The `flags` bit positions are carry=0, parity=1, auxiliary=2, zero=3, sign=4, overflow=5. Add sets carry on an unsigned carry out of the top bit. Subtract and compare set carry when unsigned a < b. Overflow is set on signed two's-complement overflow.
- R4: For every flag-writing operation, sign equals the top bit of the computed value and zero is set exactly when that value is all zeros.
- R5: Parity is set when bits 7..0 of the computed value hold an even number of ones. Auxiliary is the carry (add, increment) or borrow (subtract, compare, decrement) from bit 3 into bit 4.
- R6: Increment and decrement update parity, auxiliary, zero, sign and overflow, keep carry at its prior value, and raise `out_flags_we`.
- R7: Not and move leave all six flags unchanged, with `out_flags_we` low and `out_res_we` high.
- R8: Compare and test update all six flags, present `out_res_we` low and show `out_result` as zero.
- R9: And, or, xor and test clear carry, overflow and auxiliary.
- R10: Opcodes 11 to 15 change no flag and present both write enables low with a zero result.
- R11: After reset, `flags` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | Output stage holds a completed request |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_result | output | W | Computed value, zero when not written |
| out_res_we | output | 1 | Result is to be committed |
| out_flags_we | output | 1 | At least one flag was updated |
| flags | output | 6 | Current status register |

## Verification
The flags are the only state that lasts across requests. A wrong flag value shows on `flags` one cycle after the edge that accepted the request. It also persists into later requests, because increment and decrement carry the old carry forward, and not, move and unused codes carry every flag forward. The scoreboard therefore keeps its own flag register and compares all six bits against every output item. Sequences that set carry and then increment or execute not, and long random streams with random back-pressure, expose a mask bit written or spared wrongly within one item. A slip in the output stage under back-pressure shows as a changed or dropped item in the very next stalled cycle.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int NFLAGS = 6;
  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_O = 5;

  localparam logic [NFLAGS-1:0] MASK_ALL  = 6'b111111;
  localparam logic [NFLAGS-1:0] MASK_KEEPC = 6'b111110;
  localparam logic [NFLAGS-1:0] MASK_NONE = 6'b000000;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_TEST = 4'd6,
    OP_NOT  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_MOV  = 4'd10
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_ARITH,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOT,
    SEL_MOVE,
    SEL_NONE
  } unit_sel_e;

  typedef struct packed {
    logic              res_we;
    logic [NFLAGS-1:0] fmask;
    unit_sel_e         sel;
    logic              sub;
    logic              use_one;
  } alu_ctl_t;

endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
  import flag_alu_pkg::*;
(
  input  logic [3:0] op,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl.res_we  = 1'b0;
    ctl.fmask   = MASK_NONE;
    ctl.sel     = SEL_NONE;
    ctl.sub     = 1'b0;
    ctl.use_one = 1'b0;
    case (alu_op_e'(op))
      OP_ADD: begin
        ctl.res_we = 1'b1;
        ctl.fmask  = MASK_ALL;
        ctl.sel    = SEL_ARITH;
      end
      OP_SUB: begin
        ctl.res_we = 1'b1;
        ctl.fmask  = MASK_ALL;
        ctl.sel    = SEL_ARITH;
        ctl.sub    = 1'b1;
      end
      OP_CMP: begin
        ctl.fmask = MASK_ALL;
        ctl.sel   = SEL_ARITH;
        ctl.sub   = 1'b1;
      end
      OP_AND: begin
        ctl.res_we = 1'b1;
        ctl.fmask  = MASK_ALL;
        ctl.sel    = SEL_AND;
      end
      OP_OR: begin
        ctl.res_we = 1'b1;
        ctl.fmask  = MASK_ALL;
        ctl.sel    = SEL_OR;
      end
      OP_XOR: begin
        ctl.res_we = 1'b1;
        ctl.fmask  = MASK_ALL;
        ctl.sel    = SEL_XOR;
      end
      OP_TEST: begin
        ctl.fmask = MASK_ALL;
        ctl.sel   = SEL_AND;
      end
      OP_NOT: begin
        ctl.res_we = 1'b1;
        ctl.sel    = SEL_NOT;
      end
      OP_INC: begin
        ctl.res_we  = 1'b1;
        ctl.fmask   = MASK_KEEPC;
        ctl.sel     = SEL_ARITH;
        ctl.use_one = 1'b1;
      end
      OP_DEC: begin
        ctl.res_we  = 1'b1;
        ctl.fmask   = MASK_KEEPC;
        ctl.sel     = SEL_ARITH;
        ctl.sub     = 1'b1;
        ctl.use_one = 1'b1;
      end
      OP_MOV: begin
        ctl.res_we = 1'b1;
        ctl.sel    = SEL_MOVE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         aux,
  output logic         ovf
);

  logic [W-1:0] y;
  logic [W:0]   full;
  logic         c4;

  assign y    = sub ? ~b : b;
  assign full = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, sub};
  assign sum  = full[W-1:0];

  // carry into bit 4 recovered from the sum bit; inverted for borrow sense
  assign c4    = a[4] ^ y[4] ^ full[4];
  assign aux   = c4 ^ sub;
  assign carry = full[W] ^ sub;
  assign ovf   = (a[W-1] == y[W-1]) && (full[W-1] != a[W-1]);

endmodule

// File: rtl/flag_alu_status.sv
module flag_alu_status
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      value,
  input  logic              arith,
  input  logic              carry_in,
  input  logic              aux_in,
  input  logic              ovf_in,
  output logic [NFLAGS-1:0] fl
);

  localparam int PBITS = (W < 8) ? W : 8;

  logic [PBITS-1:0] low_bits;
  assign low_bits = value[PBITS-1:0];

  always_comb begin
    fl       = '0;
    fl[FL_C] = arith & carry_in;
    fl[FL_A] = arith & aux_in;
    fl[FL_O] = arith & ovf_in;
    fl[FL_P] = ~(^low_bits);
    fl[FL_Z] = (value == '0);
    fl[FL_S] = value[W-1];
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic              out_res_we,
  output logic              out_flags_we,
  output logic [NFLAGS-1:0] flags
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_ctl_t          ctl;
  logic              accept;
  logic [W-1:0]      opnd_b;
  logic [W-1:0]      arith_val;
  logic              ar_carry, ar_aux, ar_ovf;
  logic [W-1:0]      calc;
  logic [NFLAGS-1:0] fl_new;
  logic [NFLAGS-1:0] flags_next;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  flag_alu_decode u_dec (
    .op  (in_op),
    .ctl (ctl)
  );

  assign opnd_b = ctl.use_one ? ONE : in_b;

  flag_alu_addsub #(.W(W)) u_addsub (
    .a     (in_a),
    .b     (opnd_b),
    .sub   (ctl.sub),
    .sum   (arith_val),
    .carry (ar_carry),
    .aux   (ar_aux),
    .ovf   (ar_ovf)
  );

  always_comb begin
    case (ctl.sel)
      SEL_ARITH: calc = arith_val;
      SEL_AND:   calc = in_a & in_b;
      SEL_OR:    calc = in_a | in_b;
      SEL_XOR:   calc = in_a ^ in_b;
      SEL_NOT:   calc = ~in_a;
      SEL_MOVE:  calc = in_b;
      default:   calc = '0;
    endcase
  end

  flag_alu_status #(.W(W)) u_status (
    .value    (calc),
    .arith    (ctl.sel == SEL_ARITH),
    .carry_in (ar_carry),
    .aux_in   (ar_aux),
    .ovf_in   (ar_ovf),
    .fl       (fl_new)
  );

  assign flags_next = (flags & ~ctl.fmask) | (fl_new & ctl.fmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags        <= '0;
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_res_we   <= 1'b0;
      out_flags_we <= 1'b0;
    end else if (accept) begin
      flags        <= flags_next;
      out_valid    <= 1'b1;
      out_result   <= ctl.res_we ? calc : '0;
      out_res_we   <= ctl.res_we;
      out_flags_we <= |ctl.fmask;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_result,
  input logic              out_res_we,
  input logic              out_flags_we,
  input logic [NFLAGS-1:0] flags
);

  logic take;
  assign take = in_valid && in_ready;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result)); // R1

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid); // R1

  AST_SIGN_MSB: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_ADD || in_op == OP_SUB || in_op == OP_INC || in_op == OP_DEC)
    |=> flags[FL_S] == out_result[W-1]); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_ADD || in_op == OP_SUB || in_op == OP_AND || in_op == OP_XOR)
    |=> flags[FL_Z] == (out_result == '0)); // R4

  AST_KEEP_CARRY: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_INC || in_op == OP_DEC)
    |=> flags[FL_C] == $past(flags[FL_C]) && out_flags_we); // R6

  AST_NO_FLAG_TOUCH: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_NOT || in_op == OP_MOV)
    |=> flags == $past(flags) && !out_flags_we && out_res_we); // R7

  AST_FLAGS_ONLY: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_CMP || in_op == OP_TEST)
    |=> !out_res_we && out_flags_we && out_result == '0); // R8

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR || in_op == OP_TEST)
    |=> !flags[FL_C] && !flags[FL_O] && !flags[FL_A]); // R9

  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (rst)
    take && in_op > 4'd10
    |=> flags == $past(flags) && !out_res_we && !out_flags_we); // R10

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(flags)); // R1

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_op        (in_op),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_res_we   (out_res_we),
  .out_flags_we (out_flags_we),
  .flags        (flags)
);

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    in_op = '0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_result;
  logic          out_res_we;
  logic          out_flags_we;
  logic [5:0]    flags;

  int errors = 0;
  int checks = 0;
  bit rnd_mode = 1'b0;
  bit done = 1'b0;

  logic [5:0]   mdl_flags = '0;
  logic [W-1:0] q_res[$];
  bit           q_rwe[$];
  bit           q_fwe[$];
  logic [5:0]   q_fl[$];
  string        q_tag[$];

  always #4 clk = ~clk;

  flag_alu #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_res_we(out_res_we),
    .out_flags_we(out_flags_we), .flags(flags)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model from the requirements (flag bits C0 P1 A2 Z3 S4 O5)
  task automatic model(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, output logic [W-1:0] r,
                       output bit rwe, output bit fwe);
    logic [W-1:0] v;
    logic [W-1:0] bb;
    bit c, ax, ov, arith, is_sub, keep_c;
    v = '0; c = 0; ax = 0; ov = 0; arith = 0; is_sub = 0; keep_c = 0;
    rwe = 0; fwe = 0; bb = b;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd8, 4'd9: begin
        arith = 1;
        is_sub = (op == 4'd1 || op == 4'd2 || op == 4'd9);
        if (op == 4'd8 || op == 4'd9) begin bb = 1; keep_c = 1; end
        rwe = (op != 4'd2);
        fwe = 1;
        if (is_sub) begin
          v  = a - bb;
          c  = (a < bb);
          ax = (a[3:0] < bb[3:0]);
          ov = (a[W-1] != bb[W-1]) && (v[W-1] != a[W-1]);
        end else begin
          v  = a + bb;
          c  = (v < a);
          ax = ({1'b0, a[3:0]} + {1'b0, bb[3:0]}) > 5'd15;
          ov = (a[W-1] == bb[W-1]) && (v[W-1] != a[W-1]);
        end
      end
      4'd3: begin v = a & b; rwe = 1; fwe = 1; end
      4'd4: begin v = a | b; rwe = 1; fwe = 1; end
      4'd5: begin v = a ^ b; rwe = 1; fwe = 1; end
      4'd6: begin v = a & b; rwe = 0; fwe = 1; end
      4'd7: begin v = ~a; rwe = 1; end
      4'd10: begin v = b; rwe = 1; end
      default: ;
    endcase
    if (fwe) begin
      if (!keep_c) mdl_flags[0] = arith ? c : 1'b0;
      mdl_flags[1] = ~(^v[7:0]);
      mdl_flags[2] = arith ? ax : 1'b0;
      mdl_flags[3] = (v == '0);
      mdl_flags[4] = v[W-1];
      mdl_flags[5] = arith ? ov : 1'b0;
    end
    r = rwe ? v : '0;
  endtask

  // driver: called at posedge+2; returns at the next posedge+2 after acceptance
  task automatic send(input logic [3:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
    logic [W-1:0] r;
    bit rwe, fwe;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    model(op, a, b, r, rwe, fwe);
    q_res.push_back(r); q_rwe.push_back(rwe); q_fwe.push_back(fwe);
    q_fl.push_back(mdl_flags); q_tag.push_back(tag);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  // out_ready pattern changes just after each edge
  always @(posedge clk) begin
    #1;
    out_ready = rnd_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  bit           stalled = 1'b0;
  logic [W-1:0] stall_res = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled) begin
        check(out_valid && out_result == stall_res, "R1", "held output under stall",
              out_result, stall_res);
      end
      check(in_ready == (!out_valid || out_ready), "R1", "in_ready",
            W'(in_ready), W'(!out_valid || out_ready));
      stalled   = out_valid && !out_ready;
      stall_res = out_result;
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R1", "unexpected output item", out_result, '0);
        end else begin
          logic [W-1:0] er;
          bit erwe, efwe;
          logic [5:0] efl;
          string tg;
          er = q_res.pop_front(); erwe = q_rwe.pop_front();
          efwe = q_fwe.pop_front(); efl = q_fl.pop_front(); tg = q_tag.pop_front();
          check(out_result == er, tg, "result", out_result, er);
          check(out_res_we == erwe, tg, "res_we", W'(out_res_we), W'(erwe));
          check(out_flags_we == efwe, tg, "flags_we", W'(out_flags_we), W'(efwe));
          check(flags == efl, tg, "flags", W'(flags), W'(efl));
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", W'(out_valid), '0);
    check(flags == 6'd0, "R11", "flags after reset", W'(flags), '0);
    @(posedge clk); #2;
    rst = 1'b0;

    send(4'd0, 32'h0000_0001, 32'h0000_0001, "R2");
    send(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R3 R5");     // carry, zero, aux
    send(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R3 R4");     // overflow, sign
    send(4'd1, 32'h0000_0003, 32'h0000_0005, "R3");        // borrow
    send(4'd1, 32'h8000_0000, 32'h0000_0001, "R3");        // signed overflow on subtract
    send(4'd1, 32'h0000_0010, 32'h0000_0001, "R5");        // nibble borrow
    send(4'd0, 32'h0000_0003, 32'h0000_0000, "R5");        // parity even (two ones)
    send(4'd0, 32'h0000_0007, 32'h0000_0000, "R5");        // parity odd
    send(4'd2, 32'h1234_5678, 32'h1234_5678, "R8");        // compare equal
    send(4'd2, 32'h0000_0001, 32'h0000_0002, "R8 R3");     // compare borrow
    send(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, "R3");        // set carry
    send(4'd8, 32'hFFFF_FFFF, 32'h0, "R6");                // increment keeps carry=1
    send(4'd9, 32'h0000_0000, 32'h0, "R6");                // decrement keeps carry
    send(4'd1, 32'h0000_0005, 32'h0000_0001, "R3");        // clear carry
    send(4'd9, 32'h0000_0000, 32'h0, "R6");                // decrement with carry 0 kept
    send(4'd8, 32'h7FFF_FFFF, 32'h0, "R6 R4");             // increment overflow
    send(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, "R3");        // carry set again
    send(4'd3, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R9 R4");
    send(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, "R3");
    send(4'd4, 32'h8000_0000, 32'h0000_0001, "R9");
    send(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
    send(4'd5, 32'hAAAA_AAAA, 32'hAAAA_AAAA, "R9");
    send(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, "R3");
    send(4'd6, 32'hFF00_0000, 32'h8000_0000, "R8 R9");
    send(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, "R3");
    send(4'd7, 32'h0000_0000, 32'h0, "R7");                // not keeps all flags
    send(4'd10, 32'h0, 32'hDEAD_BEEF, "R7");               // move keeps all flags
    send(4'd11, 32'h1, 32'h1, "R10");
    send(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");

    rnd_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 4 == 1) ra = $urandom_range(0, 20);
      if (i % 4 == 2) rb = ra;
      send(4'($urandom_range(0, 15)), ra, rb, "R2 R3 R4 R5 R1");
    end
    rnd_mode = 1'b0;
    for (int i = 0; i < 100 && q_res.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    check(q_res.size() == 0, "R1", "items left in scoreboard", W'(q_res.size()), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule